// File: doc/BRIEF.md
# Conflict-Free FFT Address Generator

This block sequences a memory-based radix-4 decimation-in-time FFT of runtime-selectable size, from 16 to 4096 points. Once it accepts a start it walks every stage. In each active cycle it issues the four read locations of one butterfly, plus a twiddle index that the arithmetic unit turns into the three leg factors: leg B uses the index, leg C uses twice the index, and leg D uses three times the index. A fixed number of cycles later it issues the same four locations again as write locations, so results go back in place. When log2 of the size is odd, the radix-4 stages are followed by one radix-2 stage. That stage handles two radix-2 butterflies per cycle, so all four subbank ports stay busy.

Each location is a subbank number (0 to 3) plus a word inside that subbank. A data index goes to the subbank equal to the sum of its base-4 digits, modulo 4. Its word address is the index with the two lowest bits dropped. Under this rule the four legs of any butterfly land in four different subbanks, so single-port subbanks never collide. A bank-select bit tells which of the two ping-pong data banks the butterfly side owns. The I/O side owns the other bank, and the bit flips when a transform ends.

Top module: `fft_agen`

## Requirements
- R1: While reset is high and after it is released, rd_valid, wr_valid and done are low and pe_bank is 0.
- R2: When idle, a start with log2n in 4..12 is accepted. The first read butterfly appears one cycle after the edge that samples start, and log2n and inverse are captured on that same edge.
- R3: A transform of size N = 2^L runs floor(L/2) radix-4 stages, then one radix-2 stage if L is odd. Each stage has N/4 read cycles with the butterfly counter k rising from 0. rd_stage numbers the stages from 0.
- R4: In radix-4 stage s, the data index of leg j (j = 0..3) is the counter k with the 2-bit value j inserted at bit 2s. The bits of k below 2s keep their place, and the bits of k at 2s and above move up by two.
- R5: In the radix-2 stage, the index of leg j is k (in bits L-3..0), with bit 0 of j placed at bit L-1 and bit 1 of j placed at bit L-2. Legs 0/1 form one butterfly and legs 2/3 form the other.
- R6: The subbank of index x is the sum of the base-4 digits of x, modulo 4. Its word is x[11:2]. Leg j occupies rd_sub[2j+1:2j] and rd_word[10j+9:10j]. The four subbanks of a butterfly are always distinct.
- R7: rd_twid is a twiddle exponent in units of 2π/4096. In radix-4 stage s it is (k mod 4^s)·2^(L-2s-2)·2^(12-L). In the radix-2 stage it is k·2^(12-L), which is the factor for the legs 0/1 butterfly. With inverse set, the value is negated modulo 4096.
- R8: Every read butterfly is repeated on the wr_* ports exactly WR_LAT (2) cycles later, with the same subbanks and words. No read of stage s+1 is issued before the last write of stage s has been issued.
- R9: done is high for exactly one cycle, the cycle in which the final write of the transform is presented. pe_bank inverts on that same cycle and at no other time.
- R10: A start that arrives while a transform runs has no effect, whatever log2n it carries. A start with log2n outside 4..12 is also ignored: no reads, no done, and no change of pe_bank follow it.
- R11: A start held high during the done cycle is accepted, and the next transform begins one cycle later.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a transform (honoured only when idle) |
| log2n | input | 4 | log2 of the transform size, 4..12 |
| inverse | input | 1 | 1 selects the inverse transform (conjugate twiddles) |
| rd_valid | output | 1 | Read butterfly present |
| rd_stage | output | 3 | Stage number of the read butterfly |
| rd_sub | output | 8 | Subbank of each of the four read legs, 2 bits per leg |
| rd_word | output | 40 | Word of each of the four read legs, 10 bits per leg |
| rd_twid | output | 12 | Twiddle exponent for the read butterfly |
| wr_valid | output | 1 | Write butterfly present |
| wr_sub | output | 8 | Subbank of each of the four write legs |
| wr_word | output | 40 | Word of each of the four write legs |
| done | output | 1 | One-cycle pulse on the final write |
| pe_bank | output | 1 | Data bank currently owned by the butterfly side |

## Verification
The final write of a transform, the done pulse, the bank swap and acceptance of the next start all fall in one cycle. This is the cycle in which the generator returns to idle. The bench provokes it by holding start high during a done cycle. It judges the result by the second transform's first read arriving exactly one cycle later with the new size, and by pe_bank flipping once per transform. A start poked into the middle of a run, carrying a different size, must leave the running address stream and its done timing untouched.

// File: rtl/fft_agen_pkg.sv
package fft_agen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RUN,
    ST_DRAIN
  } agen_state_t;

  // Base-4 digit sum modulo 4 of an index (up to 32 bits wide).
  function automatic logic [1:0] digit_sum4(input logic [31:0] v);
    logic [1:0] acc;
    acc = '0;
    for (int d = 0; d < 16; d++) begin
      acc = acc + v[2*d +: 2];
    end
    return acc;
  endfunction

endpackage

// File: rtl/fft_agen_seq.sv
module fft_agen_seq
  import fft_agen_pkg::*;
#(
  parameter int LOGN_MAX = 12,
  parameter int LOGN_MIN = 4,
  parameter int WR_LAT   = 2,
  localparam int LW = $clog2(LOGN_MAX + 1),
  localparam int SW = $clog2(LOGN_MAX / 2 + 1),
  localparam int KW = LOGN_MAX - 2,
  localparam int DW = $clog2(WR_LAT + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          start,
  input  logic [LW-1:0] log2n,
  input  logic          inverse,
  output logic          issue,
  output logic [SW-1:0] stage,
  output logic [KW-1:0] k,
  output logic [LW-1:0] cfg_l,
  output logic          cfg_inv,
  output logic          radix2,
  output logic          last
);

  agen_state_t   st;
  logic [DW-1:0] dcnt;
  logic [KW-1:0] kmax;
  logic [SW-1:0] nst;
  logic [LW-1:0] kshift;
  logic          cfg_ok;
  logic          fin_stage;

  // Size-derived limits of the captured configuration.
  assign cfg_ok    = (log2n >= LW'(LOGN_MIN)) && (log2n <= LW'(LOGN_MAX));
  assign kshift    = LW'(LOGN_MAX) - cfg_l;
  assign kmax      = {KW{1'b1}} >> kshift;
  assign nst       = SW'((cfg_l + LW'(1)) >> 1);
  assign fin_stage = (stage == nst - SW'(1));
  assign radix2    = cfg_l[0] & fin_stage;
  assign issue     = (st == ST_RUN);
  assign last      = issue && fin_stage && (k == kmax);

  always_ff @(posedge clk) begin
    if (rst) begin
      st      <= ST_IDLE;
      stage   <= '0;
      k       <= '0;
      dcnt    <= '0;
      cfg_l   <= LW'(LOGN_MIN);
      cfg_inv <= 1'b0;
    end else begin
      case (st)
        ST_IDLE: begin
          if (start && cfg_ok) begin
            cfg_l   <= log2n;
            cfg_inv <= inverse;
            stage   <= '0;
            k       <= '0;
            st      <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (k == kmax) begin
            k    <= '0;
            dcnt <= '0;
            st   <= ST_DRAIN;
          end else begin
            k <= k + KW'(1);
          end
        end
        ST_DRAIN: begin
          // Let the in-flight writes of this stage leave before reading on.
          if (dcnt == DW'(WR_LAT - 1)) begin
            if (fin_stage) begin
              st <= ST_IDLE;
            end else begin
              stage <= stage + SW'(1);
              st    <= ST_RUN;
            end
          end else begin
            dcnt <= dcnt + DW'(1);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/fft_agen_map.sv
module fft_agen_map
  import fft_agen_pkg::*;
#(
  parameter int LOGN_MAX = 12,
  localparam int LW = $clog2(LOGN_MAX + 1),
  localparam int SW = $clog2(LOGN_MAX / 2 + 1),
  localparam int KW = LOGN_MAX - 2,
  localparam int IW = LOGN_MAX,
  localparam int WW = LOGN_MAX - 2
) (
  input  logic [LW-1:0]   cfg_l,
  input  logic [SW-1:0]   stage,
  input  logic [KW-1:0]   k,
  input  logic            radix2,
  output logic [7:0]      sub,
  output logic [4*WW-1:0] word
);

  logic [SW:0]   pos;
  logic [IW-1:0] kx;
  logic [IW-1:0] lo_bits;
  logic [IW-1:0] hi_bits;

  assign pos     = {stage, 1'b0};
  assign kx      = IW'(k);
  assign lo_bits = kx & ~({IW{1'b1}} << pos);
  assign hi_bits = (kx >> pos) << (pos + (SW+1)'(2));

  for (genvar j = 0; j < 4; j++) begin : g_leg
    logic [IW-1:0] idx;
    always_comb begin
      if (radix2) begin
        idx = kx | (IW'(j % 2) << (cfg_l - LW'(1)))
                 | (IW'(j / 2) << (cfg_l - LW'(2)));
      end else begin
        idx = hi_bits | (IW'(j) << pos) | lo_bits;
      end
    end
    assign sub[2*j +: 2]    = digit_sum4(32'(idx));
    assign word[WW*j +: WW] = idx[IW-1:2];
  end

endmodule

// File: rtl/fft_agen_twid.sv
module fft_agen_twid #(
  parameter int LOGN_MAX = 12,
  localparam int LW = $clog2(LOGN_MAX + 1),
  localparam int SW = $clog2(LOGN_MAX / 2 + 1),
  localparam int KW = LOGN_MAX - 2,
  localparam int TW = LOGN_MAX
) (
  input  logic [LW-1:0] cfg_l,
  input  logic [SW-1:0] stage,
  input  logic [KW-1:0] k,
  input  logic          radix2,
  input  logic          inv,
  output logic [TW-1:0] tw
);

  logic [TW-1:0] kx;
  logic [TW-1:0] low;
  logic [TW-1:0] expo;
  logic [TW-1:0] scaled;
  logic [LW-1:0] sh_stage;
  logic [LW-1:0] sh_size;

  assign kx       = TW'(k);
  assign low      = kx & ~({TW{1'b1}} << {stage, 1'b0});
  assign sh_stage = cfg_l - LW'({stage, 1'b0}) - LW'(2);
  assign sh_size  = LW'(LOGN_MAX) - cfg_l;
  assign expo     = radix2 ? kx : (low << sh_stage);
  assign scaled   = expo << sh_size;
  assign tw       = inv ? (~scaled + TW'(1)) : scaled;

endmodule

// File: rtl/fft_agen.sv
module fft_agen
  import fft_agen_pkg::*;
#(
  parameter int LOGN_MAX = 12,
  parameter int LOGN_MIN = 4,
  parameter int WR_LAT   = 2,
  localparam int LW = $clog2(LOGN_MAX + 1),
  localparam int SW = $clog2(LOGN_MAX / 2 + 1),
  localparam int KW = LOGN_MAX - 2,
  localparam int WW = LOGN_MAX - 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            start,
  input  logic [LW-1:0]   log2n,
  input  logic            inverse,
  output logic            rd_valid,
  output logic [SW-1:0]   rd_stage,
  output logic [7:0]      rd_sub,
  output logic [4*WW-1:0] rd_word,
  output logic [LOGN_MAX-1:0] rd_twid,
  output logic            wr_valid,
  output logic [7:0]      wr_sub,
  output logic [4*WW-1:0] wr_word,
  output logic            done,
  output logic            pe_bank
);

  logic            issue, last, radix2, cfg_inv;
  logic [SW-1:0]   stage;
  logic [KW-1:0]   k;
  logic [LW-1:0]   cfg_l;
  logic [7:0]      sub_c;
  logic [4*WW-1:0] word_c;
  logic [LOGN_MAX-1:0] tw_c;

  fft_agen_seq #(.LOGN_MAX(LOGN_MAX), .LOGN_MIN(LOGN_MIN), .WR_LAT(WR_LAT)) u_seq (
    .clk(clk), .rst(rst), .start(start), .log2n(log2n), .inverse(inverse),
    .issue(issue), .stage(stage), .k(k), .cfg_l(cfg_l), .cfg_inv(cfg_inv),
    .radix2(radix2), .last(last)
  );

  fft_agen_map #(.LOGN_MAX(LOGN_MAX)) u_map (
    .cfg_l(cfg_l), .stage(stage), .k(k), .radix2(radix2),
    .sub(sub_c), .word(word_c)
  );

  fft_agen_twid #(.LOGN_MAX(LOGN_MAX)) u_twid (
    .cfg_l(cfg_l), .stage(stage), .k(k), .radix2(radix2), .inv(cfg_inv),
    .tw(tw_c)
  );

  // Slot 0 holds the read butterfly; slot WR_LAT holds the matching write.
  logic            pv [0:WR_LAT];
  logic            pl [0:WR_LAT];
  logic [7:0]      ps [0:WR_LAT];
  logic [4*WW-1:0] pw [0:WR_LAT];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i <= WR_LAT; i++) begin
        pv[i] <= 1'b0;
        pl[i] <= 1'b0;
      end
    end else begin
      pv[0] <= issue;
      pl[0] <= last;
      for (int i = 1; i <= WR_LAT; i++) begin
        pv[i] <= pv[i-1];
        pl[i] <= pl[i-1];
      end
    end
  end

  always_ff @(posedge clk) begin
    ps[0]    <= sub_c;
    pw[0]    <= word_c;
    rd_stage <= stage;
    rd_twid  <= tw_c;
    for (int i = 1; i <= WR_LAT; i++) begin
      ps[i] <= ps[i-1];
      pw[i] <= pw[i-1];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pe_bank <= 1'b0;
    end else if (pv[WR_LAT-1] && pl[WR_LAT-1]) begin
      pe_bank <= ~pe_bank;
    end
  end

  assign rd_valid = pv[0];
  assign rd_sub   = ps[0];
  assign rd_word  = pw[0];
  assign wr_valid = pv[WR_LAT];
  assign wr_sub   = ps[WR_LAT];
  assign wr_word  = pw[WR_LAT];
  assign done     = pv[WR_LAT] & pl[WR_LAT];

endmodule

// File: rtl/fft_agen_chk.sv
module fft_agen_chk (
  input logic       clk,
  input logic       rst,
  input logic       rd_valid,
  input logic [7:0] rd_sub,
  input logic       wr_valid,
  input logic [7:0] wr_sub,
  input logic       done,
  input logic       pe_bank
);

  logic [3:0] rd_cover;
  logic [3:0] wr_cover;

  always_comb begin
    rd_cover = '0;
    wr_cover = '0;
    for (int j = 0; j < 4; j++) begin
      rd_cover[rd_sub[2*j +: 2]] = 1'b1;
      wr_cover[wr_sub[2*j +: 2]] = 1'b1;
    end
  end

  AST_RD_SPREAD: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> (rd_cover == 4'hF)); // R6
  AST_WR_SPREAD: assert property (@(posedge clk) disable iff (rst)
    wr_valid |-> (wr_cover == 4'hF)); // R8
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R9
  AST_BANK_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    done |-> (pe_bank != $past(pe_bank))); // R9
  AST_BANK_HELD: assert property (@(posedge clk) disable iff (rst)
    !done |-> $stable(pe_bank)); // R9
  AST_DONE_NO_READ: assert property (@(posedge clk) disable iff (rst)
    done |-> !rd_valid); // R8

endmodule

bind fft_agen fft_agen_chk u_chk (
  .clk(clk), .rst(rst), .rd_valid(rd_valid), .rd_sub(rd_sub),
  .wr_valid(wr_valid), .wr_sub(wr_sub), .done(done), .pe_bank(pe_bank)
);

// File: tb/sim_fft_agen.sv
module sim_fft_agen;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [3:0]  log2n = 4'd4;
  logic        inverse = 1'b0;
  logic        rd_valid, wr_valid, done, pe_bank;
  logic [2:0]  rd_stage;
  logic [7:0]  rd_sub, wr_sub;
  logic [39:0] rd_word, wr_word;
  logic [11:0] rd_twid;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;
  logic bk   = 1'b0;

  always #5 clk = ~clk;

  fft_agen u0 (
    .clk(clk), .rst(rst), .start(start), .log2n(log2n), .inverse(inverse),
    .rd_valid(rd_valid), .rd_stage(rd_stage), .rd_sub(rd_sub), .rd_word(rd_word),
    .rd_twid(rd_twid), .wr_valid(wr_valid), .wr_sub(wr_sub), .wr_word(wr_word),
    .done(done), .pe_bank(pe_bank)
  );

  // Stimulus table: size, inverse flag, expected stage count.
  localparam int NRUN = 8;
  localparam int RUN_L   [NRUN] = '{4, 5, 6, 7, 8, 9, 11, 12};
  localparam bit RUN_I   [NRUN] = '{0, 1, 0, 1, 1, 0, 1, 0};
  localparam int RUN_NST [NRUN] = '{2, 3, 3, 4, 4, 5, 6, 6};
  localparam int WR_LAT = 2;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  function automatic int ref_idx(int L, int s, int k, int j);
    if (s < L / 2) begin
      int lo = k % (1 << (2 * s));
      int hi = k >> (2 * s);
      return (hi << (2 * s + 2)) | (j << (2 * s)) | lo;
    end
    return ((j % 2) << (L - 1)) | ((j / 2) << (L - 2)) | k;
  endfunction

  function automatic int ref_sub(int x);
    int acc = 0;
    for (int d = 0; d < 8; d++) acc += (x >> (2 * d)) & 3;
    return acc % 4;
  endfunction

  function automatic int ref_tw(int L, int s, int k, bit inv);
    int e;
    if (s < L / 2) e = (k % (1 << (2 * s))) << (L - 2 * s - 2);
    else           e = k;
    e = e << (12 - L);
    if (inv) e = (4096 - e) % 4096;
    return e;
  endfunction

  task automatic expect_legs(input int L, input int s, input int k,
                             output logic [7:0] es, output logic [39:0] ew);
    es = '0;
    ew = '0;
    for (int j = 0; j < 4; j++) begin
      int x = ref_idx(L, s, k, j);
      es[2*j +: 2]  = 2'(ref_sub(x));
      ew[10*j +: 10] = 10'(x >> 2);
    end
  endtask

  task automatic kick(input int L, input bit inv);
    @(negedge clk);
    start = 1'b1;
    log2n = 4'(L);
    inverse = inv;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
  endtask

  // Follows one transform until done; called at the negedge after start is sampled.
  task automatic watch(input int L, input bit inv, input int exp_nst, input int poke,
                       input logic bank_before);
    int nb = 1 << (L - 2);
    int nst = (L + 1) / 2;
    int rs = 0, rk = 0, ws = 0, wk = 0, rtot = 0, wtot = 0, c = 0, seen = 0;
    bit fin = 0;
    logic [7:0]  es;
    logic [39:0] ew;
    chk(nst == exp_nst, "R3", "table stage count", nst, exp_nst);
    while (!fin && c < 20000) begin
      @(negedge clk);
      c++;
      if (poke > 0 && c == poke) begin
        start = 1'b1;
        log2n = 4'd4;
      end else if (poke > 0 && c == poke + 1) begin
        start = 1'b0;
      end
      if (wr_valid) begin
        expect_legs(L, ws, wk, es, ew);
        chk(wr_sub == es && wr_word == ew, "R8", "write legs", {wr_sub, wr_word}, {es, ew});
        wtot++;
        wk++;
        if (wk == nb) begin wk = 0; ws++; end
      end
      if (rd_valid) begin
        if (rtot == 0) chk(c == 1, "R2", "first read cycle", c, 1);
        if (rk == 0 && rs > 0) chk(wtot >= rs * nb, "R8", "stage gap writes", wtot, rs * nb);
        expect_legs(L, rs, rk, es, ew);
        chk(rd_stage == 3'(rs), "R3", "stage", rd_stage, rs);
        chk(rd_sub == es && rd_word == ew, (rs < L / 2) ? "R4/R6" : "R5/R6", "read legs",
            {rd_sub, rd_word}, {es, ew});
        chk(rd_twid == 12'(ref_tw(L, rs, rk, inv)), "R7", "twiddle", rd_twid, ref_tw(L, rs, rk, inv));
        if (rk == 0) seen++;
        rtot++;
        rk++;
        if (rk == nb) begin rk = 0; rs++; end
      end
      if (done) begin
        fin = 1;
        chk(wr_valid && wtot == nst * nb, "R9", "done on final write", wtot, nst * nb);
        chk(rtot == nst * nb && seen == exp_nst, "R3", "read cycles", rtot, nst * nb);
        chk(pe_bank == ~bank_before, "R9", "bank swap", pe_bank, ~bank_before);
      end
    end
    if (!fin) chk(1'b0, "R9", "done missing", 0, 1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!rd_valid && !wr_valid && !done && !pe_bank, "R1", "in reset",
        {rd_valid, wr_valid, done, pe_bank}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(!rd_valid && !wr_valid && !done && !pe_bank, "R1", "after reset",
        {rd_valid, wr_valid, done, pe_bank}, 0);

    for (int r = 0; r < NRUN; r++) begin
      kick(RUN_L[r], RUN_I[r]);
      watch(RUN_L[r], RUN_I[r], RUN_NST[r], 0, bk);
      bk = ~bk;
      repeat (3) @(negedge clk);
    end

    // R10: start with another size during a run is ignored.
    kick(6, 0);
    watch(6, 0, 3, 20, bk);
    bk = ~bk;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk(!rd_valid && !done, "R10", "busy start left no run", {rd_valid, done}, 0);
    end

    // R10: out-of-range sizes are refused.
    kick(3, 0);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!rd_valid && !done && pe_bank == bk, "R10", "size 3 refused", {rd_valid, done, pe_bank}, {2'b0, bk});
    end
    kick(13, 1);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      chk(!rd_valid && !done && pe_bank == bk, "R10", "size 13 refused", {rd_valid, done, pe_bank}, {2'b0, bk});
    end

    // R11: start held in the done cycle launches the next transform.
    kick(4, 0);
    watch(4, 0, 2, 0, bk);
    bk = ~bk;
    start = 1'b1;
    log2n = 4'd5;
    inverse = 1'b1;
    @(posedge clk);
    @(negedge clk);
    start = 1'b0;
    chk(rd_valid == 1'b0, "R11", "no read in accept cycle", rd_valid, 0);
    watch(5, 1, 3, 0, bk);
    bk = ~bk;

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule